// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Ready-to-Send Handshake

This block takes a serial line at a 16x oversampling tick, rebuilds one character per frame (start bit, data bits sent least significant first, an optional parity bit, one stop bit) and parks the character in a one-entry hold register. A receive-complete flag shows that the hold register carries unread data. A sticky interrupt request is raised with every finished character and stays up until it is acknowledged. Framing, parity and overrun errors are reported on flags.

The block drives an active-low ready-to-send output. It goes high (not ready) while unread data sits in the hold register or while reception is switched off. It drops low again once the character is read. An invert option returns the complement of the stored character on a read, so a link that carries inverted data can be served without extra logic.

Top module: `serial_rx_fc`

## Requirements
- R1: After reset with reception disabled, `rts_n` is 1 and `done_flag`, `irq_req`, `frame_err`, `par_err`, `ovr_err` and `rd_data` are all 0.
- R2: A frame starts with a falling edge on `rx_line` and is made of one low start bit, DATA_W data bits least significant first, and one stop bit. The bit period is 16 `os_tick` pulses. When the frame is complete, the character is stored and `done_flag` becomes 1.
- R3: With `cfg_par_en`=1 a parity bit follows the last data bit. `cfg_par_odd`=0 selects even parity, meaning that data plus parity holds an even number of ones; `cfg_par_odd`=1 selects odd parity. A mismatch sets `par_err`. A mismatch with `cfg_par_en`=0 is not possible because no parity bit is taken.
- R4: A start bit that reads high at its middle sample (the eighth tick) is a false start. The receiver goes back to idle and stores nothing.
- R5: A stop bit that samples low sets `frame_err`. The character is still stored.
- R6: One `rd_strobe` cycle loads `rd_data` on the next clock. The value is the stored character with `cfg_invert`=0, and its bitwise complement with `cfg_invert`=1.
- R7: `rts_n` is 1 while `done_flag` is 1 or `rx_en` is 0. It returns to 0 on the clock after the read that empties the hold register.
- R8: `irq_req` is set when a character completes. It stays set, even across reads, until `irq_ack` is pulsed.
- R9: If a character completes while `done_flag` is already 1 and no read happens in that cycle, `ovr_err` is set and the new character replaces the old one.
- R10: A read clears `done_flag`, `frame_err`, `par_err` and `ovr_err`.
- R11: While `rx_en` is 0 no frame is received and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_line | input | 1 | Serial data in, idle high |
| rx_en | input | 1 | Reception enable |
| rd_strobe | input | 1 | Read of the hold register |
| irq_ack | input | 1 | Clears the interrupt request |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| cfg_invert | input | 1 | Return complemented data on a read |
| rd_data | output | DATA_W | Data from the last read |
| rts_n | output | 1 | Ready to send, active low |
| done_flag | output | 1 | Hold register holds unread data |
| irq_req | output | 1 | Sticky receive interrupt request |
| frame_err | output | 1 | Stop bit sampled low |
| par_err | output | 1 | Parity mismatch |
| ovr_err | output | 1 | Unread character overwritten |

## Verification
The hardest case to reach is the overrun. It needs a second full frame to finish while the first character is still unread, with no read in the capture cycle. The bench reaches it by turning off the monitor's automatic reads, sending two frames back to back, and then checking that the second character replaced the first and that one read clears the error. False starts are reached with a short low pulse, well under half a bit. A real frame follows the pulse to show that the receiver has gone back to idle.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[i] <= 1'b1;
          else     pipe[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[i] <= 1'b1;
          else     pipe[i] <= pipe[i-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rx_s,
  input  logic              rx_en,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              cap,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_ferr,
  output logic              cap_perr
);
  localparam int CW  = $clog2(OSR);
  localparam int BW  = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] BLAST = BW'(DATA_W - 1);

  rx_state_e         st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bcnt;
  logic [DATA_W-1:0] shreg;
  logic              pbit;
  logic              prev;
  logic              at_mid;
  logic              at_bit;

  assign at_mid = os_tick && (cnt == MID);
  assign at_bit = os_tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RX_IDLE;
      cnt      <= '0;
      bcnt     <= '0;
      shreg    <= '0;
      pbit     <= 1'b0;
      prev     <= 1'b1;
      cap      <= 1'b0;
      cap_data <= '0;
      cap_ferr <= 1'b0;
      cap_perr <= 1'b0;
    end else begin
      prev <= rx_s;
      cap  <= 1'b0;
      if (os_tick) cnt <= cnt + 1'b1;
      if (!rx_en) begin
        st <= RX_IDLE;
      end else begin
        unique case (st)
          RX_IDLE: begin
            if (prev && !rx_s) begin
              st  <= RX_START;
              cnt <= '0;
            end
          end
          RX_START: begin
            if (at_mid) begin
              cnt  <= '0;
              bcnt <= '0;
              st   <= rx_s ? RX_IDLE : RX_DATA;
            end
          end
          RX_DATA: begin
            if (at_bit) begin
              shreg <= {rx_s, shreg[DATA_W-1:1]};
              bcnt  <= bcnt + 1'b1;
              if (bcnt == BLAST) st <= par_en ? RX_PAR : RX_STOP;
            end
          end
          RX_PAR: begin
            if (at_bit) begin
              pbit <= rx_s;
              st   <= RX_STOP;
            end
          end
          RX_STOP: begin
            if (at_bit) begin
              cap      <= 1'b1;
              cap_data <= shreg;
              cap_ferr <= !rx_s;
              cap_perr <= par_en && ((^shreg ^ pbit) != par_odd);
              st       <= RX_IDLE;
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              cap_ferr,
  input  logic              cap_perr,
  input  logic              rd,
  input  logic              ack,
  input  logic              inv,
  input  logic              rx_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              irq,
  output logic              ferr,
  output logic              perr,
  output logic              ovr,
  output logic              rts_n
);
  logic [DATA_W-1:0] hold;
  logic              full_nx;

  assign full_nx = cap ? 1'b1 : (rd ? 1'b0 : full);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold    <= '0;
      rd_data <= '0;
      full    <= 1'b0;
      irq     <= 1'b0;
      ferr    <= 1'b0;
      perr    <= 1'b0;
      ovr     <= 1'b0;
      rts_n   <= 1'b1;
    end else begin
      full  <= full_nx;
      rts_n <= full_nx || !rx_en;
      if (rd) rd_data <= hold ^ {DATA_W{inv}};
      if (cap) hold <= cap_data;
      ferr <= (ferr && !rd) || (cap && cap_ferr);
      perr <= (perr && !rd) || (cap && cap_perr);
      ovr  <= (ovr && !rd) || (cap && full && !rd);
      irq  <= (irq && !ack) || cap;
    end
  end
endmodule

// File: rtl/serial_rx_fc.sv
module serial_rx_fc #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rx_line,
  input  logic              rx_en,
  input  logic              rd_strobe,
  input  logic              irq_ack,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_invert,
  output logic [DATA_W-1:0] rd_data,
  output logic              rts_n,
  output logic              done_flag,
  output logic              irq_req,
  output logic              frame_err,
  output logic              par_err,
  output logic              ovr_err
);
  logic              rx_s;
  logic              cap_vld;
  logic [DATA_W-1:0] cap_data;
  logic              cap_ferr;
  logic              cap_perr;

  serial_rx_sync #(.STAGES(SYNC)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_line),
    .dout (rx_s)
  );

  serial_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .os_tick  (os_tick),
    .rx_s     (rx_s),
    .rx_en    (rx_en),
    .par_en   (cfg_par_en),
    .par_odd  (cfg_par_odd),
    .cap      (cap_vld),
    .cap_data (cap_data),
    .cap_ferr (cap_ferr),
    .cap_perr (cap_perr)
  );

  serial_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .cap      (cap_vld),
    .cap_data (cap_data),
    .cap_ferr (cap_ferr),
    .cap_perr (cap_perr),
    .rd       (rd_strobe),
    .ack      (irq_ack),
    .inv      (cfg_invert),
    .rx_en    (rx_en),
    .rd_data  (rd_data),
    .full     (done_flag),
    .irq      (irq_req),
    .ferr     (frame_err),
    .perr     (par_err),
    .ovr      (ovr_err),
    .rts_n    (rts_n)
  );
endmodule

// File: rtl/serial_rx_fc_chk.sv
module serial_rx_fc_chk (
  input logic clk,
  input logic rst,
  input logic rx_en,
  input logic rd_strobe,
  input logic irq_ack,
  input logic cap,
  input logic rts_n,
  input logic done_flag,
  input logic irq_req,
  input logic frame_err,
  input logic par_err,
  input logic ovr_err
);
  AST_RTS_WHEN_FULL: assert property (@(posedge clk) disable iff (rst) done_flag |-> rts_n); // R7
  AST_RTS_WHEN_OFF: assert property (@(posedge clk) disable iff (rst) !rx_en |=> rts_n); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst) irq_req && !irq_ack |=> irq_req); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst) rd_strobe && !cap |=> !done_flag && !frame_err && !par_err && !ovr_err); // R10
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst) $rose(ovr_err) |-> $past(done_flag)); // R9
  AST_DONE_FROM_FRAME: assert property (@(posedge clk) disable iff (rst) $rose(done_flag) |-> $past(cap)); // R2
  AST_FLAGS_NEED_FULL: assert property (@(posedge clk) disable iff (rst) (frame_err || par_err || ovr_err) |-> done_flag); // R5
endmodule

bind serial_rx_fc serial_rx_fc_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rx_en     (rx_en),
  .rd_strobe (rd_strobe),
  .irq_ack   (irq_ack),
  .cap       (cap_vld),
  .rts_n     (rts_n),
  .done_flag (done_flag),
  .irq_req   (irq_req),
  .frame_err (frame_err),
  .par_err   (par_err),
  .ovr_err   (ovr_err)
);

// File: tb/serial_rx_fc_tb.sv
module serial_rx_fc_tb;
  localparam int DW   = 8;
  localparam int TDIV = 4;
  localparam int BITC = 16 * TDIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic os_tick = 1'b0;
  logic rx_line = 1'b1;
  logic rx_en = 1'b0;
  logic rd_strobe = 1'b0;
  logic irq_ack = 1'b0;
  logic cfg_par_en = 1'b0;
  logic cfg_par_odd = 1'b0;
  logic cfg_invert = 1'b0;
  logic [DW-1:0] rd_data;
  logic rts_n, done_flag, irq_req, frame_err, par_err, ovr_err;

  int n_chk = 0;
  int n_bad = 0;
  bit auto_rd = 1'b1;

  typedef struct {
    logic [DW-1:0] val;
    logic          fe;
    logic          pe;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  serial_rx_fc u_dut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_line(rx_line), .rx_en(rx_en),
    .rd_strobe(rd_strobe), .irq_ack(irq_ack), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_invert(cfg_invert), .rd_data(rd_data),
    .rts_n(rts_n), .done_flag(done_flag), .irq_req(irq_req),
    .frame_err(frame_err), .par_err(par_err), .ovr_err(ovr_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin : g_tick
    forever begin
      for (int i = 0; i < TDIV; i++) begin
        @(negedge clk);
        os_tick = (i == TDIV - 1);
      end
    end
  end

  task automatic hold_bit(input logic b);
    rx_line = b;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic send(input logic [DW-1:0] d, input bit bad_par, input bit stop_ok, input bit push);
    logic p;
    exp_t e;
    p = (^d) ^ cfg_par_odd ^ bad_par;
    e.val = cfg_invert ? ~d : d;
    e.fe  = !stop_ok;
    e.pe  = cfg_par_en && bad_par;
    if (push) sb.push_back(e);
    hold_bit(1'b0);
    for (int i = 0; i < DW; i++) hold_bit(d[i]);
    if (cfg_par_en) hold_bit(p);
    hold_bit(stop_ok);
    hold_bit(1'b1);
  endtask

  task automatic do_read();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic do_ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin : g_mon
    exp_t e;
    forever begin
      @(negedge clk);
      if (auto_rd && done_flag && sb.size() > 0) begin
        e = sb.pop_front();
        check("R7 rts_n high while full", rts_n, 1);
        check("R8 irq set on completion", irq_req, 1);
        check("R5 frame_err", frame_err, e.fe);
        check("R3 par_err", par_err, e.pe);
        check("R9 no overrun", ovr_err, 0);
        do_read();
        check("R6 rd_data", rd_data, e.val);
        check("R10 done cleared by read", done_flag, 0);
        check("R10 errors cleared by read", {frame_err, par_err, ovr_err}, 0);
        check("R7 rts_n low after read", rts_n, 0);
        check("R8 irq survives read", irq_req, 1);
        do_ack();
        check("R8 irq cleared by ack", irq_req, 0);
      end
    end
  end

  initial begin : g_dog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic drain();
    while (sb.size() > 0 || done_flag) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin : g_main
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rts_n", rts_n, 1);
    check("R1 flags", {done_flag, irq_req, frame_err, par_err, ovr_err}, 0);
    check("R1 rd_data", rd_data, 0);

    // R11 disabled receiver ignores a frame
    send(8'hA5, 0, 1, 0);
    check("R11 no capture while disabled", {done_flag, irq_req}, 0);
    check("R7 rts_n high while disabled", rts_n, 1);

    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 rts_n low when enabled and empty", rts_n, 0);

    // R2 plain frames, LSB first
    send(8'h35, 0, 1, 1);
    send(8'hC1, 0, 1, 1);
    send(8'h00, 0, 1, 1);
    send(8'hFF, 0, 1, 1);
    drain();

    // R6 invert
    cfg_invert = 1'b1;
    send(8'h3C, 0, 1, 1);
    drain();
    cfg_invert = 1'b0;

    // R3 parity even and odd, good and bad
    cfg_par_en = 1'b1;
    send(8'h17, 0, 1, 1);
    send(8'h17, 1, 1, 1);
    cfg_par_odd = 1'b1;
    send(8'h80, 0, 1, 1);
    send(8'h80, 1, 1, 1);
    drain();
    cfg_par_en = 1'b0;
    cfg_par_odd = 1'b0;

    // R5 framing error
    send(8'h5A, 0, 0, 1);
    drain();

    // R4 false start then a real frame
    rx_line = 1'b0;
    repeat (16) @(negedge clk);
    rx_line = 1'b1;
    repeat (BITC * 12) @(negedge clk);
    check("R4 false start stores nothing", {done_flag, irq_req}, 0);
    send(8'h96, 0, 1, 1);
    drain();

    // R9 overrun
    auto_rd = 1'b0;
    send(8'h11, 0, 1, 0);
    check("R9 first stored", done_flag, 1);
    check("R9 no overrun yet", ovr_err, 0);
    send(8'h22, 0, 1, 0);
    check("R9 overrun set", ovr_err, 1);
    check("R7 rts_n high while full", rts_n, 1);
    do_read();
    check("R9 newer character kept", rd_data, 8'h22);
    check("R10 overrun cleared by read", ovr_err, 0);
    check("R7 rts_n low after read", rts_n, 0);
    check("R8 irq still set", irq_req, 1);
    do_ack();
    check("R8 irq cleared", irq_req, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule